// File: doc/BRIEF.md
# Audio Sample Rate Strobe Generator

This block turns one master enable strobe, running at 1,411,200 Hz, into three sample-rate strobes: one for each of two playback channels and one for a capture channel. Each output is a single-clock pulse that the channel's sample mover uses to step by one sample. The master strobe is made elsewhere from the system clock. This block only counts its pulses.

Playback channel 1 uses a four-way power-of-two divider chosen by a 2-bit rate select. The nominal rates are 5512, 11025, 22050 and 44100 Hz. Playback channel 2 and the capture channel share one 13-bit divider value N and run at 1,411,200 / (N + 2). Software picks N as the rounded quotient of 1,411,200 by the wanted rate, minus 2. A sync option makes playback 2 follow the playback 1 rate instead of its own divider. In a register map these inputs usually come from one control word: rate select in bits 13:12, N in bits 28:16, sync in bit 11, and the enables in bits 6, 5 and 4 (playback 1, playback 2, capture).

Top module: `srate_strobe_gen`

## Requirements
- R1: With playback 1 enabled, `pb1_tick` fires once every 256, 128, 64 or 32 master strobes for `rate_sel` values 0, 1, 2 and 3.
- R2: With sync off, `pb2_tick` fires once every `div_n` + 2 master strobes. `cap_tick` always uses that same period, for every `div_n` from 0 to 8191.
- R3: A `div_n` equal to round(1411200 / f) − 2 gives the same period as playback 1 at rate f for f = 11025, 22050 and 44100, so the two channels tick in the same cycles.
- R4: With `sync_pb2` high, `pb2_tick` follows the playback 1 rate and `div_n` has no effect on it. When both playback channels are enabled, their ticks fall in the same cycle.
- R5: A channel whose enable is low produces no tick. Playback 2 in sync mode still ticks when playback 1 is disabled.
- R6: The first tick after a channel is enabled comes one full period after enabling. Disabling a channel restarts its count.
- R7: A change to `rate_sel` or `div_n` while a channel runs leaves the current period unchanged. The new period starts at the next tick of that channel.
- R8: Every tick is high for exactly one clock, in the clock right after the master strobe that completes the period. All ticks are low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_tick | input | 1 | 1,411,200 Hz enable strobe, one clock wide |
| rate_sel | input | 2 | Playback 1 rate select |
| div_n | input | 13 | Shared divider value N for playback 2 and capture |
| sync_pb2 | input | 1 | Playback 2 runs at the playback 1 rate |
| en_pb1 | input | 1 | Playback 1 enable |
| en_pb2 | input | 1 | Playback 2 enable |
| en_cap | input | 1 | Capture enable |
| pb1_tick | output | 1 | Playback 1 sample strobe |
| pb2_tick | output | 1 | Playback 2 sample strobe |
| cap_tick | output | 1 | Capture sample strobe |

## Verification
Two pairs of outputs can pulse in the same cycle. In sync mode, playback 2 and playback 1 share one power-of-two count, so their ticks must fall in the same cycle. With sync off, a `div_n` derived from a playback 1 rate gives playback 2 and capture the same period as playback 1. The bench enables all channels in the same cycle and counts the cycles in which pairs of ticks coincide, which must equal the tick count of each channel. Any one-cycle skew between the paths shows up as a mismatch.

// File: rtl/srate_pkg.sv
package srate_pkg;

    // Width of the playback 1 rate select.
    localparam int SEL_W    = 2;
    // Width of the shared divider value N.
    localparam int DIV_W    = 13;
    // log2 of the slowest power-of-two period (select value 0).
    localparam int SLOW_LOG = 8;

    // One bit per output strobe.
    typedef struct packed {
        logic pb1;
        logic pb2;
        logic cap;
    } strobe_t;

endpackage

// File: rtl/srate_pow2_div.sv
module srate_pow2_div #(
    parameter int SEL_W    = srate_pkg::SEL_W,
    parameter int SLOW_LOG = srate_pkg::SLOW_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mstr_tick,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);

    localparam int CNT_W = SLOW_LOG;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W:0]   period;
    logic [CNT_W-1:0] reload;

    // Period halves for each step of the select value.
    always_comb begin
        period = (CNT_W + 1)'(1) << (CNT_W - 32'(sel));
        reload = CNT_W'(period - (CNT_W + 1)'(1));
    end

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!run) begin
            st_d.cnt = reload;
        end else if (mstr_tick) begin
            if (st_q.cnt == '0) begin
                fire     = 1'b1;
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/srate_prog_div.sv
module srate_prog_div #(
    parameter int DIV_W = srate_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mstr_tick,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             fire
);

    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] reload;

    // Reload to N + 1 so that N + 2 master strobes make one period.
    always_comb reload = {1'b0, div_n} + CNT_W'(1);

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!run) begin
            st_d.cnt = reload;
        end else if (mstr_tick) begin
            if (st_q.cnt == '0) begin
                fire     = 1'b1;
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/srate_strobe_gen.sv
module srate_strobe_gen
    import srate_pkg::*;
#(
    parameter int P_SEL_W    = SEL_W,
    parameter int P_DIV_W    = DIV_W,
    parameter int P_SLOW_LOG = SLOW_LOG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_tick,
    input  logic [P_SEL_W-1:0] rate_sel,
    input  logic [P_DIV_W-1:0] div_n,
    input  logic               sync_pb2,
    input  logic               en_pb1,
    input  logic               en_pb2,
    input  logic               en_cap,
    output logic               pb1_tick,
    output logic               pb2_tick,
    output logic               cap_tick
);

    localparam int N_PROG = 2;   // index 0: playback 2, index 1: capture

    logic              pow_run;
    logic              pow_fire;
    logic [N_PROG-1:0] prog_run;
    logic [N_PROG-1:0] prog_fire;
    strobe_t           out_d, out_q;

    // The power-of-two counter also serves playback 2 in sync mode.
    always_comb begin
        pow_run     = en_pb1 | (en_pb2 & sync_pb2);
        prog_run[0] = en_pb2 & ~sync_pb2;
        prog_run[1] = en_cap;
    end

    srate_pow2_div #(
        .SEL_W    (P_SEL_W),
        .SLOW_LOG (P_SLOW_LOG)
    ) u_pow2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mstr_tick (master_tick),
        .run       (pow_run),
        .sel       (rate_sel),
        .fire      (pow_fire)
    );

    for (genvar g = 0; g < N_PROG; g++) begin : g_prog
        srate_prog_div #(
            .DIV_W (P_DIV_W)
        ) u_prog (
            .clk       (clk),
            .rst_n     (rst_n),
            .mstr_tick (master_tick),
            .run       (prog_run[g]),
            .div_n     (div_n),
            .fire      (prog_fire[g])
        );
    end

    always_comb begin
        out_d     = '0;
        out_d.pb1 = en_pb1 & pow_fire;
        out_d.pb2 = en_pb2 & (sync_pb2 ? pow_fire : prog_fire[0]);
        out_d.cap = en_cap & prog_fire[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pb1_tick = out_q.pb1;
    assign pb2_tick = out_q.pb2;
    assign cap_tick = out_q.cap;

endmodule

// File: rtl/srate_strobe_gen_chk.sv
module srate_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic master_tick,
    input logic sync_pb2,
    input logic en_pb1,
    input logic en_pb2,
    input logic en_cap,
    input logic pb1_tick,
    input logic pb2_tick,
    input logic cap_tick
);

    a_r5_pb1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_pb1) |-> !pb1_tick);

    a_r5_cap_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_cap) |-> !cap_tick);

    a_r8_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        (pb1_tick || pb2_tick || cap_tick) |-> $past(master_tick));

    a_r1_pb1_single: assert property (@(posedge clk) disable iff (!rst_n)
        pb1_tick |=> !pb1_tick);

    a_r2_cap_single: assert property (@(posedge clk) disable iff (!rst_n)
        cap_tick |=> !cap_tick);

    a_r4_sync_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_pb2 && en_pb1 && en_pb2) |-> (pb2_tick == pb1_tick));

endmodule

bind srate_strobe_gen srate_strobe_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_tick (master_tick),
    .sync_pb2    (sync_pb2),
    .en_pb1      (en_pb1),
    .en_pb2      (en_pb2),
    .en_cap      (en_cap),
    .pb1_tick    (pb1_tick),
    .pb2_tick    (pb2_tick),
    .cap_tick    (cap_tick)
);

// File: tb/srate_strobe_gen_bench.sv
module srate_strobe_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_tick = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic [12:0] div_n = '0;
    logic        sync_pb2 = 1'b0;
    logic        en_pb1 = 1'b0;
    logic        en_pb2 = 1'b0;
    logic        en_cap = 1'b0;
    logic        pb1_tick, pb2_tick, cap_tick;

    int checks = 0;
    int errors = 0;
    int wide_err = 0;
    int nc [3];
    int fi [3];
    int pv [3];
    int gmin [3];
    int gmax [3];
    int both12;
    int both2c;

    always #10 clk = ~clk;

    srate_strobe_gen u_srate_strobe_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_tick (master_tick),
        .rate_sel    (rate_sel),
        .div_n       (div_n),
        .sync_pb2    (sync_pb2),
        .en_pb1      (en_pb1),
        .en_pb2      (en_pb2),
        .en_cap      (en_cap),
        .pb1_tick    (pb1_tick),
        .pb2_tick    (pb2_tick),
        .cap_tick    (cap_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One master strobe; outputs sampled in the clock after it, then must drop.
    task automatic mtick(output logic [2:0] obs);
        @(negedge clk);
        master_tick = 1'b1;
        @(negedge clk);
        master_tick = 1'b0;
        obs = {pb1_tick, pb2_tick, cap_tick};
        @(posedge clk);
        #1;
        if (pb1_tick || pb2_tick || cap_tick) wide_err++;
    endtask

    task automatic measure(input int n);
        logic [2:0] obs;
        both12 = 0;
        both2c = 0;
        for (int c = 0; c < 3; c++) begin
            nc[c] = 0; fi[c] = 0; pv[c] = 0; gmin[c] = 1 << 30; gmax[c] = 0;
        end
        for (int i = 1; i <= n; i++) begin
            mtick(obs);
            if (obs[2] && obs[1]) both12++;
            if (obs[1] && obs[0]) both2c++;
            for (int c = 0; c < 3; c++) begin
                if (obs[2-c]) begin
                    if (nc[c] == 0) fi[c] = i;
                    else begin
                        if (i - pv[c] < gmin[c]) gmin[c] = i - pv[c];
                        if (i - pv[c] > gmax[c]) gmax[c] = i - pv[c];
                    end
                    pv[c] = i;
                    nc[c]++;
                end
            end
        end
    endtask

    task automatic setup(input int sel, input int n, input bit sy,
                         input bit e1, input bit e2, input bit e3);
        en_pb1 = 1'b0; en_pb2 = 1'b0; en_cap = 1'b0;
        rate_sel = 2'(sel);
        div_n = 13'(n);
        sync_pb2 = sy;
        repeat (2) @(posedge clk);
        #1;
        en_pb1 = e1; en_pb2 = e2; en_cap = e3;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p;
        int nn;
        repeat (5) @(posedge clk);
        #1;
        // R8: reset state
        chk("R8", "pb1 at reset", int'(pb1_tick), 0);
        chk("R8", "pb2 at reset", int'(pb2_tick), 0);
        chk("R8", "cap at reset", int'(cap_tick), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // R5: all channels disabled
        setup(3, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        measure(600);
        chk("R5", "pb1 while off", nc[0], 0);
        chk("R5", "pb2 while off", nc[1], 0);
        chk("R5", "cap while off", nc[2], 0);

        // R1 and R6: power-of-two rates, first tick one period after enable
        for (int s = 0; s < 4; s++) begin
            p = 256 >> s;
            setup(s, 0, 1'b0, 1'b1, 1'b0, 1'b0);
            measure(4 * p);
            chk("R1", $sformatf("pb1 count sel %0d", s), nc[0], 4);
            chk("R6", $sformatf("pb1 first sel %0d", s), fi[0], p);
            chk("R1", $sformatf("pb1 gap min sel %0d", s), gmin[0], p);
            chk("R1", $sformatf("pb1 gap max sel %0d", s), gmax[0], p);
            chk("R5", $sformatf("pb2 idle sel %0d", s), nc[1], 0);
            chk("R5", $sformatf("cap idle sel %0d", s), nc[2], 0);
        end

        // R2: shared divider sweep plus the largest value
        for (int n = 0; n <= 41; n++) begin
            nn = (n == 41) ? 8191 : n;
            setup(0, nn, 1'b0, 1'b0, 1'b1, 1'b1);
            measure((n == 41 ? 2 : 3) * (nn + 2));
            chk("R2", $sformatf("pb2 count N %0d", nn), nc[1], n == 41 ? 2 : 3);
            chk("R2", $sformatf("pb2 first N %0d", nn), fi[1], nn + 2);
            chk("R2", $sformatf("pb2 gap N %0d", nn), gmax[1], nn + 2);
            chk("R2", $sformatf("cap count N %0d", nn), nc[2], n == 41 ? 2 : 3);
            chk("R2", $sformatf("cap gap N %0d", nn), gmin[2], nn + 2);
            chk("R2", $sformatf("pb2 cap together N %0d", nn), both2c, nc[1]);
            chk("R5", $sformatf("pb1 idle N %0d", nn), nc[0], 0);
        end

        // R3: divider from rounded quotient matches playback 1 rate
        for (int s = 1; s < 4; s++) begin
            int f;
            f = 44100 >> (3 - s);
            nn = (1411200 + f / 2) / f - 2;
            setup(s, nn, 1'b0, 1'b1, 1'b1, 1'b1);
            measure(3 * (256 >> s));
            chk("R3", $sformatf("pb2 count f %0d", f), nc[1], 3);
            chk("R3", $sformatf("pb1 pb2 same cycle f %0d", f), both12, 3);
            chk("R3", $sformatf("cap gap f %0d", f), gmax[2], 256 >> s);
        end

        // R4: sync with playback 1 off, then with all on
        setup(3, 5, 1'b1, 1'b0, 1'b1, 1'b0);
        measure(64);
        chk("R4", "sync pb2 count", nc[1], 2);
        chk("R4", "sync pb2 first", fi[1], 32);
        chk("R5", "sync pb1 stays off", nc[0], 0);
        setup(3, 5, 1'b1, 1'b1, 1'b1, 1'b1);
        measure(224);
        chk("R4", "sync pb1 count", nc[0], 7);
        chk("R4", "sync pb2 count all on", nc[1], 7);
        chk("R4", "sync same cycle", both12, 7);
        chk("R4", "cap keeps divider", nc[2], 32);
        chk("R4", "cap gap", gmax[2], 7);

        // R7: mid-period divider change
        setup(0, 10, 1'b0, 1'b0, 1'b1, 1'b0);
        measure(5);
        chk("R7", "pb2 none yet", nc[1], 0);
        div_n = 13'd3;
        measure(7);
        chk("R7", "pb2 old period ends", fi[1], 7);
        measure(10);
        chk("R7", "pb2 new period count", nc[1], 2);
        chk("R7", "pb2 new period first", fi[1], 5);

        // R7: mid-period rate select change
        setup(0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        measure(100);
        chk("R7", "pb1 none yet", nc[0], 0);
        rate_sel = 2'd3;
        measure(220);
        chk("R7", "pb1 old period ends", fi[0], 156);
        chk("R7", "pb1 ticks after change", nc[0], 3);
        chk("R7", "pb1 new gap", gmax[0], 32);

        // R6: disabling restarts the count
        setup(0, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        measure(7);
        en_cap = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        en_cap = 1'b1;
        measure(12);
        chk("R6", "cap first after re-enable", fi[2], 12);
        chk("R6", "cap count after re-enable", nc[2], 1);

        // R8: every tick one clock wide
        chk("R8", "ticks wider than one clock", wide_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule